// File: doc/BRIEF.md
# Address Match Trigger Comparator

This block compares every configured hardware breakpoint slot against the current instruction fetch and the current data access in the same cycle. Each slot supplies a control word and a compare address. The control word selects one of two layouts: a legacy layout (type code 2) and an extended layout (type code 6) that adds enables for the virtualized user and supervisor levels. The block also takes the fetch PC, the data address with its direction and size, the current privilege level and a virtualization flag.

When any armed slot matches, the block raises a breakpoint request combinationally, so that the pipeline can take the exception before the instruction or access completes. It also returns a per-slot match vector. One cycle later, a registered hit strobe reports the lowest-numbered matching slot. Chaining, data-value compare and trace actions are not part of this block.

Top module: `trig_addr_match`

## Requirements
- R1: An execute match requires `fetch_vld_i`, execute-enable bit 2 set in the control word, and `fetch_pc_i` equal to the slot's compare address.
- R2: A data match requires `mem_vld_i`. A load (`mem_we_i`=0) is qualified by load-enable bit 0 and a store (`mem_we_i`=1) by store-enable bit 1. The other direction never matches.
- R3: Outside virtualization, a slot fires only if the enable bit at position 3+priv is set: user (priv 0) is bit 3, supervisor (priv 1) is bit 4, machine (priv 3) is bit 6. A slot with none of its privilege enables set never fires.
- R4: For the extended layout, when `virt_i` is 1 the virtual enables replace bits 3/4/6. Virtual user (priv 0) is bit 23 and virtual supervisor (priv 1) is bit 24.
- R5: A legacy-layout slot never fires while `virt_i` is 1.
- R6: Only slots whose type field (the top 4 bits of the control word) is 2 or 6 can fire. All other type codes never match.
- R7: With size code 0 ("any"), or an unsupported size code (4, 6 to 15), a data access matches only when its start address equals the compare address exactly.
- R8: The size code is {bits 22:21, bits 17:16} for the legacy layout (bits 22:21 are used only when XLEN is 64) and bits 19:16 for the extended layout. Codes 1, 2, 3 and 5 mean 1, 2, 4 and 8 bytes. A sized slot matches a data access of 2^`mem_size_i` bytes whose byte range overlaps [compare address, compare address + length).
- R9: `brk_req_o` and `match_vec_o` respond combinationally in the same cycle as the access. All slots are evaluated in parallel.
- R10: `hit_vld_o` is high in the cycle after a cycle in which `brk_req_o` was high. `hit_idx_o` then carries the lowest-numbered matching slot. Reset clears `hit_vld_o` and `hit_idx_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tdata1_i | input | NUM_TRIG x XLEN | Per-slot control word |
| tdata2_i | input | NUM_TRIG x XLEN | Per-slot compare address |
| fetch_vld_i | input | 1 | Instruction fetch present |
| fetch_pc_i | input | XLEN | Fetch PC |
| mem_vld_i | input | 1 | Data access present |
| mem_we_i | input | 1 | 1 = store, 0 = load |
| mem_addr_i | input | XLEN | Data access start address |
| mem_size_i | input | 2 | log2 of access bytes |
| priv_i | input | 2 | Privilege: 0 user, 1 supervisor, 3 machine |
| virt_i | input | 1 | Virtualized mode active |
| brk_req_o | output | 1 | Breakpoint request, same cycle |
| match_vec_o | output | NUM_TRIG | Per-slot match |
| hit_vld_o | output | 1 | Registered hit strobe |
| hit_idx_o | output | IDXW | Registered lowest matching slot |

## Verification
The bench targets the privilege selection that changes with the virtualization flag. It checks that a supervisor-enabled extended slot stays quiet when virtualized but fires when not virtualized, and that a legacy slot with the right bit still stays quiet when virtualized. A design that indexed the wrong bit, or forgot to suppress the legacy layout, would fire on the wrong level. Size handling is probed at both edges: an access one past the end of the window, an access that starts below the window and straddles into it, the 8-byte code that needs the high size bits, and unsupported codes that must fall back to exact-address compare. A design that ignored the high size bits or treated code 4 as a length would mismatch. Two slots hitting together check that the registered index picks the lower one and not the higher one.

// File: rtl/trig_pkg.sv
package trig_pkg;

   localparam logic [3:0] TYPE_LEGACY = 4'd2;
   localparam logic [3:0] TYPE_EXT    = 4'd6;

   localparam int BIT_LD  = 0;
   localparam int BIT_ST  = 1;
   localparam int BIT_EX  = 2;
   localparam int BIT_U   = 3;
   localparam int BIT_S   = 4;
   localparam int BIT_M   = 6;
   localparam int BIT_VU  = 23;
   localparam int BIT_VS  = 24;

   // size code to window length in bytes; 0 means exact start compare
   function automatic logic [3:0] size_to_len(input logic [3:0] code);
      case (code)
         4'd1:    size_to_len = 4'd1;
         4'd2:    size_to_len = 4'd2;
         4'd3:    size_to_len = 4'd4;
         4'd5:    size_to_len = 4'd8;
         default: size_to_len = 4'd0;
      endcase
   endfunction

endpackage

// File: rtl/trig_ctl_decode.sv
module trig_ctl_decode
   import trig_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [XLEN-1:0] ctl_i,
   output logic            is_leg_o,
   output logic            is_ext_o,
   output logic            en_u_o,
   output logic            en_s_o,
   output logic            en_m_o,
   output logic            en_vu_o,
   output logic            en_vs_o,
   output logic            en_ld_o,
   output logic            en_st_o,
   output logic            en_ex_o,
   output logic [3:0]      len_o
);

   localparam int TYPE_LSB = XLEN - 4;

   logic [3:0] type_f;
   logic [3:0] sz_leg;
   logic [3:0] sz_ext;
   logic       unused_ctl;

   assign type_f   = ctl_i[TYPE_LSB +: 4];
   assign is_leg_o = (type_f == TYPE_LEGACY);
   assign is_ext_o = (type_f == TYPE_EXT);

   generate
      if (XLEN == 64) begin : g_sz64
         assign sz_leg = {ctl_i[22:21], ctl_i[17:16]};
      end else begin : g_sz32
         assign sz_leg = {2'b00, ctl_i[17:16]};
      end
   endgenerate

   assign sz_ext = ctl_i[19:16];

   assign en_u_o  = ctl_i[BIT_U];
   assign en_s_o  = ctl_i[BIT_S];
   assign en_m_o  = ctl_i[BIT_M];
   assign en_vu_o = is_ext_o & ctl_i[BIT_VU];
   assign en_vs_o = is_ext_o & ctl_i[BIT_VS];
   assign en_ld_o = ctl_i[BIT_LD];
   assign en_st_o = ctl_i[BIT_ST];
   assign en_ex_o = ctl_i[BIT_EX];
   assign len_o   = size_to_len(is_ext_o ? sz_ext : sz_leg);

   assign unused_ctl = ^ctl_i;

   AST_LEN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(len_o)); // R8

endmodule

// File: rtl/trig_cmp.sv
module trig_cmp #(
   parameter int XLEN = 64
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            is_leg_i,
   input  logic            is_ext_i,
   input  logic            en_u_i,
   input  logic            en_s_i,
   input  logic            en_m_i,
   input  logic            en_vu_i,
   input  logic            en_vs_i,
   input  logic            en_ld_i,
   input  logic            en_st_i,
   input  logic            en_ex_i,
   input  logic [3:0]      len_i,
   input  logic [XLEN-1:0] cmp_addr_i,
   input  logic            fetch_vld_i,
   input  logic [XLEN-1:0] fetch_pc_i,
   input  logic            mem_vld_i,
   input  logic            mem_we_i,
   input  logic [XLEN-1:0] mem_addr_i,
   input  logic [1:0]      mem_size_i,
   input  logic [1:0]      priv_i,
   input  logic            virt_i,
   output logic            hit_o
);

   localparam int EW = XLEN + 1;

   logic          mode_any;
   logic          kind_any;
   logic          armed;
   logic          lvl_ok;
   logic          ex_hit;
   logic          dir_ok;
   logic          addr_hit;
   logic [EW-1:0] win_lo;
   logic [EW-1:0] win_hi;
   logic [EW-1:0] acc_lo;
   logic [EW-1:0] acc_hi;

   assign mode_any = en_u_i | en_s_i | en_m_i | en_vu_i | en_vs_i;
   assign kind_any = en_ld_i | en_st_i | en_ex_i;
   assign armed    = (is_leg_i | is_ext_i) & mode_any & kind_any;

   always_comb begin
      lvl_ok = 1'b0;
      if (virt_i) begin
         if (is_ext_i) begin
            case (priv_i)
               2'd0:    lvl_ok = en_vu_i;
               2'd1:    lvl_ok = en_vs_i;
               default: lvl_ok = 1'b0;
            endcase
         end
      end else begin
         case (priv_i)
            2'd0:    lvl_ok = en_u_i;
            2'd1:    lvl_ok = en_s_i;
            2'd3:    lvl_ok = en_m_i;
            default: lvl_ok = 1'b0;
         endcase
      end
   end

   assign ex_hit = fetch_vld_i & en_ex_i & (fetch_pc_i == cmp_addr_i);
   assign dir_ok = mem_vld_i & (mem_we_i ? en_st_i : en_ld_i);

   assign win_lo = {1'b0, cmp_addr_i};
   assign win_hi = win_lo + EW'(len_i);
   assign acc_lo = {1'b0, mem_addr_i};
   assign acc_hi = acc_lo + (EW'(1) << mem_size_i);

   always_comb begin
      if (len_i == 4'd0) addr_hit = (mem_addr_i == cmp_addr_i);
      else               addr_hit = (acc_lo < win_hi) && (win_lo < acc_hi);
   end

   assign hit_o = armed & lvl_ok & (ex_hit | (dir_ok & addr_hit));

   AST_LEG_VIRT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (is_leg_i && virt_i) |-> !hit_o); // R5
   AST_NO_MODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !(en_u_i || en_s_i || en_m_i || en_vu_i || en_vs_i) |-> !hit_o); // R3
   AST_FETCH_ONLY_PC: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_o && !mem_vld_i) |-> (fetch_vld_i && fetch_pc_i == cmp_addr_i)); // R1
   AST_TYPE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |-> (is_leg_i || is_ext_i)); // R6

endmodule

// File: rtl/trig_lowest.sv
module trig_lowest #(
   parameter int N    = 4,
   parameter int IDXW = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N-1:0]    req_i,
   output logic            any_o,
   output logic [IDXW-1:0] idx_o
);

   logic [N-1:0] below_mask;

   always_comb begin
      any_o = 1'b0;
      idx_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req_i[i]) begin
            any_o = 1'b1;
            idx_o = IDXW'(i);
         end
      end
   end

   assign below_mask = (N'(1) << idx_o) - N'(1);

   AST_IDX_IS_SET: assert property (@(posedge clk) disable iff (!rst_n)
      any_o |-> req_i[idx_o]); // R10
   AST_IDX_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
      any_o |-> ((req_i & below_mask) == '0)); // R10

endmodule

// File: rtl/trig_addr_match.sv
module trig_addr_match #(
   parameter int NUM_TRIG = 4,
   parameter int XLEN     = 64,
   localparam int IDXW    = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_TRIG-1:0][XLEN-1:0] tdata1_i,
   input  logic [NUM_TRIG-1:0][XLEN-1:0] tdata2_i,
   input  logic                          fetch_vld_i,
   input  logic [XLEN-1:0]               fetch_pc_i,
   input  logic                          mem_vld_i,
   input  logic                          mem_we_i,
   input  logic [XLEN-1:0]               mem_addr_i,
   input  logic [1:0]                    mem_size_i,
   input  logic [1:0]                    priv_i,
   input  logic                          virt_i,
   output logic                          brk_req_o,
   output logic [NUM_TRIG-1:0]           match_vec_o,
   output logic                          hit_vld_o,
   output logic [IDXW-1:0]               hit_idx_o
);

   generate
      if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
         $error("trig_addr_match: XLEN must be 32 or 64");
      end
      if (NUM_TRIG < 1) begin : g_bad_num
         $error("trig_addr_match: NUM_TRIG must be at least 1");
      end
   endgenerate

   logic            any_hit;
   logic [IDXW-1:0] low_idx;

   generate
      for (genvar g = 0; g < NUM_TRIG; g++) begin : g_slot
         logic       is_leg, is_ext;
         logic       en_u, en_s, en_m, en_vu, en_vs;
         logic       en_ld, en_st, en_ex;
         logic [3:0] len;

         trig_ctl_decode #(.XLEN(XLEN)) u_dec (
            .clk      (clk),
            .rst_n    (rst_n),
            .ctl_i    (tdata1_i[g]),
            .is_leg_o (is_leg),
            .is_ext_o (is_ext),
            .en_u_o   (en_u),
            .en_s_o   (en_s),
            .en_m_o   (en_m),
            .en_vu_o  (en_vu),
            .en_vs_o  (en_vs),
            .en_ld_o  (en_ld),
            .en_st_o  (en_st),
            .en_ex_o  (en_ex),
            .len_o    (len)
         );

         trig_cmp #(.XLEN(XLEN)) u_cmp (
            .clk         (clk),
            .rst_n       (rst_n),
            .is_leg_i    (is_leg),
            .is_ext_i    (is_ext),
            .en_u_i      (en_u),
            .en_s_i      (en_s),
            .en_m_i      (en_m),
            .en_vu_i     (en_vu),
            .en_vs_i     (en_vs),
            .en_ld_i     (en_ld),
            .en_st_i     (en_st),
            .en_ex_i     (en_ex),
            .len_i       (len),
            .cmp_addr_i  (tdata2_i[g]),
            .fetch_vld_i (fetch_vld_i),
            .fetch_pc_i  (fetch_pc_i),
            .mem_vld_i   (mem_vld_i),
            .mem_we_i    (mem_we_i),
            .mem_addr_i  (mem_addr_i),
            .mem_size_i  (mem_size_i),
            .priv_i      (priv_i),
            .virt_i      (virt_i),
            .hit_o       (match_vec_o[g])
         );
      end
   endgenerate

   trig_lowest #(.N(NUM_TRIG), .IDXW(IDXW)) u_low (
      .clk   (clk),
      .rst_n (rst_n),
      .req_i (match_vec_o),
      .any_o (any_hit),
      .idx_o (low_idx)
   );

   assign brk_req_o = any_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit_vld_o <= 1'b0;
         hit_idx_o <= '0;
      end else begin
         hit_vld_o <= any_hit;
         hit_idx_o <= any_hit ? low_idx : '0;
      end
   end

   AST_HIT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      brk_req_o |=> hit_vld_o); // R10
   AST_HIT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      !brk_req_o |=> !hit_vld_o); // R10
   AST_REQ_HAS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      brk_req_o |-> (match_vec_o != '0)); // R9

endmodule

// File: tb/trig_addr_match_tb.sv
`timescale 1ns/100ps
module trig_addr_match_tb;

   localparam int NT = 4;
   localparam int XL = 64;
   localparam int IW = 2;
   localparam int NV = 25;

   typedef struct packed {
      logic [63:0] t1;
      logic [63:0] t2;
      logic        fv;
      logic [63:0] pc;
      logic        mv;
      logic        we;
      logic [63:0] addr;
      logic [1:0]  sz;
      logic [1:0]  pr;
      logic        vt;
      logic        exp;
      logic [7:0]  req;
   } vec_t;

   localparam logic [63:0] A = 64'h1000;

   localparam vec_t VECS [NV] = '{
      '{64'h2000_0000_0000_0044, A, 1'b1, A,          1'b0, 1'b0, 64'h0,    2'd0, 2'd3, 1'b0, 1'b1, 8'd1}, // R1 exec hit
      '{64'h2000_0000_0000_0044, A, 1'b1, 64'h1004,   1'b0, 1'b0, 64'h0,    2'd0, 2'd3, 1'b0, 1'b0, 8'd1}, // R1 wrong pc
      '{64'h2000_0000_0000_0044, A, 1'b1, A,          1'b0, 1'b0, 64'h0,    2'd0, 2'd0, 1'b0, 1'b0, 8'd3}, // R3 M only, in U
      '{64'h2000_0000_0000_000C, A, 1'b1, A,          1'b0, 1'b0, 64'h0,    2'd0, 2'd0, 1'b0, 1'b1, 8'd3}, // R3 U enable
      '{64'h2000_0000_0000_0014, A, 1'b1, A,          1'b0, 1'b0, 64'h0,    2'd0, 2'd1, 1'b1, 1'b0, 8'd5}, // R5 legacy virt
      '{64'h6000_0000_0100_0004, A, 1'b1, A,          1'b0, 1'b0, 64'h0,    2'd0, 2'd1, 1'b1, 1'b1, 8'd4}, // R4 VS
      '{64'h6000_0000_0000_0014, A, 1'b1, A,          1'b0, 1'b0, 64'h0,    2'd0, 2'd1, 1'b1, 1'b0, 8'd4}, // R4 S ignored when virt
      '{64'h6000_0000_0000_0014, A, 1'b1, A,          1'b0, 1'b0, 64'h0,    2'd0, 2'd1, 1'b0, 1'b1, 8'd4}, // R4 S when not virt
      '{64'h2000_0000_0000_0041, A, 1'b0, 64'h0,      1'b1, 1'b0, A,        2'd0, 2'd3, 1'b0, 1'b1, 8'd2}, // R2 load
      '{64'h2000_0000_0000_0041, A, 1'b0, 64'h0,      1'b1, 1'b1, A,        2'd0, 2'd3, 1'b0, 1'b0, 8'd2}, // R2 store vs load-only
      '{64'h2000_0000_0000_0042, A, 1'b0, 64'h0,      1'b1, 1'b1, A,        2'd0, 2'd3, 1'b0, 1'b1, 8'd2}, // R2 store
      '{64'h2000_0000_0000_0041, A, 1'b0, 64'h0,      1'b1, 1'b0, 64'h1001, 2'd0, 2'd3, 1'b0, 1'b0, 8'd7}, // R7 any: exact
      '{64'h2000_0000_0003_0041, A, 1'b0, 64'h0,      1'b1, 1'b0, 64'h1002, 2'd0, 2'd3, 1'b0, 1'b1, 8'd8}, // R8 4B inside
      '{64'h2000_0000_0003_0041, A, 1'b0, 64'h0,      1'b1, 1'b0, 64'h1004, 2'd0, 2'd3, 1'b0, 1'b0, 8'd8}, // R8 one past end
      '{64'h2000_0000_0003_0041, A, 1'b0, 64'h0,      1'b1, 1'b0, 64'h0FFE, 2'd2, 2'd3, 1'b0, 1'b1, 8'd8}, // R8 straddle
      '{64'h2000_0000_0021_0041, A, 1'b0, 64'h0,      1'b1, 1'b0, 64'h1007, 2'd0, 2'd3, 1'b0, 1'b1, 8'd8}, // R8 8B via high bits
      '{64'h6000_0000_0005_0041, A, 1'b0, 64'h0,      1'b1, 1'b0, 64'h1007, 2'd0, 2'd3, 1'b0, 1'b1, 8'd8}, // R8 ext 8B
      '{64'h6000_0000_0004_0041, A, 1'b0, 64'h0,      1'b1, 1'b0, 64'h1002, 2'd0, 2'd3, 1'b0, 1'b0, 8'd7}, // R7 code 4 -> exact
      '{64'h6000_0000_0004_0041, A, 1'b0, 64'h0,      1'b1, 1'b0, A,        2'd0, 2'd3, 1'b0, 1'b1, 8'd7}, // R7 code 4 exact hit
      '{64'h2000_0000_0000_0004, A, 1'b1, A,          1'b0, 1'b0, 64'h0,    2'd0, 2'd3, 1'b0, 1'b0, 8'd3}, // R3 no levels
      '{64'h3000_0000_0000_0044, A, 1'b1, A,          1'b0, 1'b0, 64'h0,    2'd0, 2'd3, 1'b0, 1'b0, 8'd6}, // R6 other type
      '{64'h2000_0000_0000_0044, A, 1'b0, A,          1'b0, 1'b0, 64'h0,    2'd0, 2'd3, 1'b0, 1'b0, 8'd1}, // R1 no fetch
      '{64'h6000_0000_0080_0001, A, 1'b0, 64'h0,      1'b1, 1'b0, A,        2'd0, 2'd0, 1'b1, 1'b1, 8'd4}, // R4 VU load
      '{64'h2000_0000_0001_0041, A, 1'b0, 64'h0,      1'b1, 1'b0, 64'h0FFF, 2'd1, 2'd3, 1'b0, 1'b1, 8'd8}, // R8 1B window, 2B access
      '{64'h2000_0000_0020_0041, A, 1'b0, 64'h0,      1'b1, 1'b0, 64'h1001, 2'd0, 2'd3, 1'b0, 1'b0, 8'd7}  // R7 code 4 legacy
   };

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic [NT-1:0][XL-1:0]   tdata1, tdata2;
   logic                    fetch_vld, mem_vld, mem_we, virt;
   logic [XL-1:0]           fetch_pc, mem_addr;
   logic [1:0]              mem_size, priv;
   logic                    brk_req, hit_vld;
   logic [NT-1:0]           match_vec;
   logic [IW-1:0]           hit_idx;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   trig_addr_match #(.NUM_TRIG(NT), .XLEN(XL)) u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .tdata1_i    (tdata1),
      .tdata2_i    (tdata2),
      .fetch_vld_i (fetch_vld),
      .fetch_pc_i  (fetch_pc),
      .mem_vld_i   (mem_vld),
      .mem_we_i    (mem_we),
      .mem_addr_i  (mem_addr),
      .mem_size_i  (mem_size),
      .priv_i      (priv),
      .virt_i      (virt),
      .brk_req_o   (brk_req),
      .match_vec_o (match_vec),
      .hit_vld_o   (hit_vld),
      .hit_idx_o   (hit_idx)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic idle();
      tdata1 = '0; tdata2 = '0;
      fetch_vld = 1'b0; fetch_pc = '0;
      mem_vld = 1'b0; mem_we = 1'b0; mem_addr = '0; mem_size = 2'd0;
      priv = 2'd3; virt = 1'b0;
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
      #0.5;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      idle();
      repeat (3) @(negedge clk);
      #0.5;
      chk("R10 reset hit_vld", 64'(hit_vld), 64'd0);
      chk("R10 reset hit_idx", 64'(hit_idx), 64'd0);
      @(negedge clk);
      rst_n = 1'b1;
      step();
      chk("R10 idle after reset", 64'(hit_vld), 64'd0);

      for (int v = 0; v < NV; v++) begin
         idle();
         tdata1[0] = VECS[v].t1;  tdata2[0] = VECS[v].t2;
         fetch_vld = VECS[v].fv;  fetch_pc  = VECS[v].pc;
         mem_vld   = VECS[v].mv;  mem_we    = VECS[v].we;
         mem_addr  = VECS[v].addr; mem_size = VECS[v].sz;
         priv      = VECS[v].pr;  virt      = VECS[v].vt;
         #0.5;
         n_run++;
         if (brk_req !== VECS[v].exp || match_vec !== {3'b000, VECS[v].exp}) begin
            n_fail++;
            $display("FAIL R%0d vector %0d: actual brk %b vec %b expected %b",
                     VECS[v].req, v, brk_req, match_vec, VECS[v].exp);
         end
         step();
         chk("R10 registered strobe", 64'(hit_vld), 64'(VECS[v].exp));
      end

      // R10: slots 1 and 3 both hit, lowest wins
      idle();
      tdata1[1] = 64'h2000_0000_0000_0044; tdata2[1] = 64'h2000;
      tdata1[3] = 64'h2000_0000_0000_0044; tdata2[3] = 64'h2000;
      fetch_vld = 1'b1; fetch_pc = 64'h2000;
      #0.5;
      chk("R9 two slots vec", 64'(match_vec), 64'b1010);
      chk("R10 before edge", 64'(hit_vld), 64'd0);
      step();
      chk("R10 lowest idx", 64'(hit_idx), 64'd1);
      chk("R10 strobe", 64'(hit_vld), 64'd1);

      tdata1[1] = '0;
      #0.5;
      step();
      chk("R10 only slot 3", 64'(hit_idx), 64'd3);

      // R9: fetch and data matched on different slots in one cycle
      idle();
      tdata1[0] = 64'h2000_0000_0000_0044; tdata2[0] = 64'h3000;
      tdata1[2] = 64'h6000_0000_0000_0042; tdata2[2] = 64'h4000;
      fetch_vld = 1'b1; fetch_pc = 64'h3000;
      mem_vld = 1'b1; mem_we = 1'b1; mem_addr = 64'h4000;
      #0.5;
      chk("R9 parallel vec", 64'(match_vec), 64'b0101);
      chk("R9 brk same cycle", 64'(brk_req), 64'd1);
      step();
      chk("R10 parallel idx", 64'(hit_idx), 64'd0);

      // R10: reset while matching clears the strobe
      rst_n = 1'b0;
      #0.5;
      chk("R10 async reset", 64'(hit_vld), 64'd0);
      step();
      rst_n = 1'b1;
      step();
      chk("R10 after release", 64'(hit_vld), 64'd1);

      idle();
      #0.5;
      step();
      chk("R10 clears when idle", 64'(hit_vld), 64'd0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule